// File: doc/BRIEF.md
# ADC Trigger Rearm Sequencer

This block sits between the trigger sources of an analog-to-digital converter and its conversion engine. It takes single-cycle software and hardware trigger pulses and turns each accepted one into a one-cycle start-conversion strobe. If the converter has been left idle for a long time, its analog core can drift, so the block has a low-frequency option. With that option on, each accepted trigger first sends a one-cycle rearm pulse to the analog core. The start strobe then follows a fixed number of clock cycles later (two by default).

Whether a rearm is needed depends on the power mode. With automatic power-off the core is woken fresh for every conversion, so the rearm step is skipped. In wait mode only the first accepted trigger after the converter is enabled rearms the core, and later triggers start at normal latency. After a trigger is accepted, the block stays busy until the conversion engine reports completion. Triggers that arrive while it is busy are discarded and flagged with a one-cycle pulse. Turning the converter off aborts any pending sequence and clears the record of the first trigger.

Top module: `adc_rearm_seq`

## Requirements
- R1: While reset is asserted, and for the cycles right after it, `rearm_o`, `start_o`, `busy_o` and `trig_drop_o` are all 0.
- R2: With `lf_mode`=0, an accepted trigger (sw_trig or hw_trig high at a clock edge while enabled and not busy) gives `start_o` high for one cycle in the cycle right after the trigger, and gives no `rearm_o`.
- R3: With `lf_mode`=1, `autooff_mode`=0 and `wait_mode`=0, every accepted trigger, software or hardware, gives `rearm_o` in the cycle after the trigger. `start_o` then follows exactly REARM_DLY cycles (default 2) after `rearm_o`.
- R4: With `autooff_mode`=1, no rearm is issued even if `lf_mode`=1, and the start comes at the R2 latency.
- R5: With `lf_mode`=1 and `wait_mode`=1, only the first accepted trigger since `adc_en` rose is rearmed. Later triggers start at the R2 latency.
- R6: Driving `adc_en` low clears the first-trigger record, so the first trigger after re-enabling in wait mode is rearmed again.
- R7: `busy_o` is high from the cycle after an accepted trigger until the cycle after `conv_done` is seen during the conversion. A trigger in the first idle cycle after that is accepted.
- R8: A trigger that arrives while `busy_o` is high (rearm, delay, start or conversion pending) produces no rearm and no start. It raises `trig_drop_o` for one cycle, in the next cycle.
- R9: `rearm_o` and `start_o` are each one cycle wide and are never high in the same cycle. No pulse appears unless it was caused by an accepted trigger.
- R10: While `adc_en` is 0, triggers are ignored: no pulses are produced and `trig_drop_o` stays low. Dropping `adc_en` returns a pending sequence to idle in the next cycle, with no further start.
- R11: Software and hardware triggers in the same cycle count as one trigger and produce a single sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adc_en | input | 1 | Converter enabled |
| lf_mode | input | 1 | Low-frequency trigger option: rearm before start |
| autooff_mode | input | 1 | Automatic power-off active; disables rearm |
| wait_mode | input | 1 | Wait mode active; only the first trigger rearms |
| sw_trig | input | 1 | Software trigger pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| conv_done | input | 1 | Conversion complete pulse from the engine |
| rearm_o | output | 1 | One-cycle rearm command to the analog core |
| start_o | output | 1 | One-cycle start-conversion strobe |
| busy_o | output | 1 | Sequence or conversion pending |
| trig_drop_o | output | 1 | One-cycle pulse: a trigger was discarded |

## Verification
The bench checks the exact cycle of each start after a rearm. A hold counter that is off by one would move the start one cycle early or late, and the scoreboard would reject it. The bench sends a trigger during the rearm cycle itself. A design that took it would emit a second rearm or start, and a design that missed it would leave the scheduled drop pulse unmatched. Wait mode is run across a disable and re-enable: a first-trigger flag that never clears loses the rearm after re-enable, and one that clears too often rearms every trigger. The bench also drops `adc_en` in the middle of a sequence and checks that the pending start never appears.

// File: rtl/adc_rearm_pkg.sv
package adc_rearm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REARM = 3'd1,
    ST_HOLD  = 3'd2,
    ST_START = 3'd3,
    ST_CONV  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/adc_rearm_rst_sync.sv
module adc_rearm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/adc_rearm_policy.sv
module adc_rearm_policy (
  input  logic clk,
  input  logic rst_n,
  input  logic adc_en,
  input  logic accept,
  input  logic lf_mode,
  input  logic autooff_mode,
  input  logic wait_mode,
  output logic need_rearm
);

  logic first_seen_q;
  logic first_seen_d;
  logic first_seen_en;

  always_comb begin
    first_seen_en = !adc_en || accept;
    first_seen_d  = adc_en && accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             first_seen_q <= 1'b0;
    else if (first_seen_en) first_seen_q <= first_seen_d;
  end

  assign need_rearm = lf_mode && !autooff_mode && !(wait_mode && first_seen_q);

endmodule

// File: rtl/adc_rearm_hold.sv
module adc_rearm_hold #(
  parameter int REARM_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CW = (REARM_DLY > 2) ? $clog2(REARM_DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(REARM_DLY - 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    cnt_en = load || (run && !expired);
    cnt_d  = load ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_rearm_seq.sv
module adc_rearm_seq
  import adc_rearm_pkg::*;
#(
  parameter int REARM_DLY  = 2,
  parameter int SYNC_STAGE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adc_en,
  input  logic lf_mode,
  input  logic autooff_mode,
  input  logic wait_mode,
  input  logic sw_trig,
  input  logic hw_trig,
  input  logic conv_done,
  output logic rearm_o,
  output logic start_o,
  output logic busy_o,
  output logic trig_drop_o
);

  logic       rst_q_n;
  seq_state_e state_q;
  seq_state_e state_d;
  logic       state_en;
  logic       trig_any;
  logic       is_idle;
  logic       accept;
  logic       drop_d;
  logic       drop_q;
  logic       need_rearm;
  logic       hold_expired;

  adc_rearm_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q_n)
  );

  adc_rearm_policy u_policy (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .adc_en       (adc_en),
    .accept       (accept),
    .lf_mode      (lf_mode),
    .autooff_mode (autooff_mode),
    .wait_mode    (wait_mode),
    .need_rearm   (need_rearm)
  );

  adc_rearm_hold #(.REARM_DLY(REARM_DLY)) u_hold (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load    (state_q == ST_REARM),
    .run     (state_q == ST_HOLD),
    .expired (hold_expired)
  );

  always_comb begin
    trig_any = sw_trig || hw_trig;
    is_idle  = (state_q == ST_IDLE);
    accept   = adc_en && is_idle && trig_any;
    drop_d   = adc_en && !is_idle && trig_any;
  end

  always_comb begin
    state_d = state_q;
    if (!adc_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (accept) state_d = need_rearm ? ST_REARM : ST_START;
        ST_REARM: state_d = ST_HOLD;
        ST_HOLD:  if (hold_expired) state_d = ST_START;
        ST_START: state_d = ST_CONV;
        ST_CONV:  if (conv_done) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) drop_q <= 1'b0;
    else          drop_q <= drop_d;
  end

  assign rearm_o     = (state_q == ST_REARM);
  assign start_o     = (state_q == ST_START);
  assign busy_o      = !is_idle;
  assign trig_drop_o = drop_q;

endmodule

// File: rtl/adc_rearm_seq_chk.sv
module adc_rearm_seq_chk #(
  parameter int REARM_DLY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic adc_en,
  input logic lf_mode,
  input logic autooff_mode,
  input logic sw_trig,
  input logic hw_trig,
  input logic conv_done,
  input logic rearm_o,
  input logic start_o,
  input logic busy_o,
  input logic trig_drop_o
);

  localparam int GW = $clog2(REARM_DLY + 2) + 1;

  logic          pend_q;
  logic [GW-1:0] gap_q;
  logic          trig;

  assign trig = sw_trig || hw_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      gap_q  <= '0;
    end else if (!adc_en || start_o) begin
      pend_q <= 1'b0;
    end else if (rearm_o) begin
      pend_q <= 1'b1;
      gap_q  <= GW'(1);
    end else if (pend_q && gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R9
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rearm_o && start_o));

  // R9
  rearm_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_o |=> !rearm_o);

  // R9
  start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R3
  rearm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && pend_q) |-> (gap_q == GW'(REARM_DLY)));

  // R2
  plain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && !busy_o && trig && !lf_mode) |=> (start_o && !rearm_o));

  // R4
  autooff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && !busy_o && trig && autooff_mode) |=> (start_o && !rearm_o));

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && busy_o && trig) |=> trig_drop_o);

  // R10
  off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> (!busy_o && !rearm_o && !start_o && !trig_drop_o));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(conv_done || !adc_en));

endmodule

bind adc_rearm_seq adc_rearm_seq_chk #(.REARM_DLY(REARM_DLY)) chk_i (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .adc_en       (adc_en),
  .lf_mode      (lf_mode),
  .autooff_mode (autooff_mode),
  .sw_trig      (sw_trig),
  .hw_trig      (hw_trig),
  .conv_done    (conv_done),
  .rearm_o      (rearm_o),
  .start_o      (start_o),
  .busy_o       (busy_o),
  .trig_drop_o  (trig_drop_o)
);

// File: tb/adc_rearm_seq_tb_top.sv
`timescale 1ns/1ps
module adc_rearm_seq_tb_top;

  localparam int DLY = 2;
  localparam int K_REARM = 1;
  localparam int K_START = 2;
  localparam int K_DROP  = 3;

  logic clk = 1'b0;
  logic rst_n, adc_en, lf_mode, autooff_mode, wait_mode;
  logic sw_trig, hw_trig, conv_done;
  logic rearm_o, start_o, busy_o, trig_drop_o;

  always #2 clk = ~clk;

  adc_rearm_seq #(.REARM_DLY(DLY)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .adc_en       (adc_en),
    .lf_mode      (lf_mode),
    .autooff_mode (autooff_mode),
    .wait_mode    (wait_mode),
    .sw_trig      (sw_trig),
    .hw_trig      (hw_trig),
    .conv_done    (conv_done),
    .rearm_o      (rearm_o),
    .start_o      (start_o),
    .busy_o       (busy_o),
    .trig_drop_o  (trig_drop_o)
  );

  typedef struct {
    int    kind;
    int    at;
    string req;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic report();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic push(int kind, int at, string req);
    exp_t e;
    e.kind = kind;
    e.at   = at;
    e.req  = req;
    sb.push_back(e);
  endtask

  task automatic match(int kind);
    int idx = -1;
    for (int i = 0; i < sb.size(); i++) begin
      if (idx < 0 && sb[i].kind == kind && sb[i].at == cyc) idx = i;
    end
    if (idx >= 0) begin
      chk(1'b1, sb[idx].req, "pulse", kind, kind);
      sb.delete(idx);
    end else begin
      chk(1'b0, "R9", "unscheduled pulse kind", kind, 0);
    end
  endtask

  // Monitor: compares each produced pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rearm_o && start_o) chk(1'b0, "R9", "rearm with start", 1, 0);
      if (rearm_o)     match(K_REARM);
      if (start_o)     match(K_START);
      if (trig_drop_o) match(K_DROP);
    end
  end

  // Driver: mode 0 none, 1 plain start, 2 rearm+start, 3 drop, 4 rearm only
  task automatic fire(bit s, bit h, int mode, string req);
    int t = cyc;
    sw_trig = s;
    hw_trig = h;
    case (mode)
      1: push(K_START, t + 1, req);
      2: begin push(K_REARM, t + 1, req); push(K_START, t + 1 + DLY, req); end
      3: push(K_DROP, t + 1, req);
      4: push(K_REARM, t + 1, req);
      default: ;
    endcase
    @(negedge clk);
    sw_trig = 1'b0;
    hw_trig = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic conv_end(string req);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    chk(busy_o == 1'b0, req, "busy after conv_done", busy_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; adc_en = 1'b0; lf_mode = 1'b0; autooff_mode = 1'b0;
    wait_mode = 1'b0; sw_trig = 1'b0; hw_trig = 1'b0; conv_done = 1'b0;
    wait_cyc(3);
    // R1
    chk(rearm_o == 0, "R1", "rearm in reset", rearm_o, 0);
    chk(start_o == 0, "R1", "start in reset", start_o, 0);
    chk(busy_o == 0, "R1", "busy in reset", busy_o, 0);
    chk(trig_drop_o == 0, "R1", "drop in reset", trig_drop_o, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
    adc_en = 1'b1;
    wait_cyc(2);

    // R2 plain start, software then hardware
    fire(1, 0, 1, "R2");
    wait_cyc(2);
    chk(busy_o == 1, "R7", "busy during conversion", busy_o, 1);
    conv_end("R7");
    fire(0, 1, 1, "R2");   // R7: accepted in first idle cycle
    wait_cyc(2);
    conv_end("R7");

    // R3 rearm path, both sources
    lf_mode = 1'b1;
    fire(1, 0, 2, "R3");
    wait_cyc(3);
    conv_end("R3");
    fire(0, 1, 2, "R3");
    wait_cyc(3);
    // R8 trigger during conversion
    fire(1, 0, 3, "R8");
    chk(busy_o == 1, "R8", "busy kept after drop", busy_o, 1);
    conv_end("R8");

    // R8 trigger during the rearm cycle
    fire(0, 1, 2, "R3");
    fire(1, 0, 3, "R8");
    wait_cyc(3);
    conv_end("R8");

    // R11 both sources in one cycle
    fire(1, 1, 2, "R11");
    wait_cyc(3);
    conv_end("R11");

    // R4 auto-off skips rearm
    autooff_mode = 1'b1;
    fire(1, 0, 1, "R4");
    wait_cyc(2);
    conv_end("R4");
    autooff_mode = 1'b0;

    // R5 wait mode: first trigger after enable only
    adc_en = 1'b0;
    wait_cyc(2);
    adc_en = 1'b1;
    wait_mode = 1'b1;
    wait_cyc(1);
    fire(1, 0, 2, "R5");
    wait_cyc(3);
    conv_end("R5");
    fire(0, 1, 1, "R5");
    wait_cyc(2);
    conv_end("R5");
    fire(1, 0, 1, "R5");
    wait_cyc(2);
    conv_end("R5");

    // R6 disable clears the first-trigger record
    adc_en = 1'b0;
    wait_cyc(2);
    adc_en = 1'b1;
    wait_cyc(1);
    fire(1, 0, 2, "R6");
    wait_cyc(3);
    conv_end("R6");
    wait_mode = 1'b0;

    // R10 triggers ignored while disabled
    adc_en = 1'b0;
    wait_cyc(1);
    fire(1, 1, 0, "R10");
    wait_cyc(2);
    chk(busy_o == 0, "R10", "busy while disabled", busy_o, 0);
    chk(trig_drop_o == 0, "R10", "drop while disabled", trig_drop_o, 0);

    // R10 abort after rearm: no start may follow
    adc_en = 1'b1;
    wait_cyc(1);
    fire(1, 0, 4, "R10");
    adc_en = 1'b0;
    wait_cyc(1);
    chk(busy_o == 0, "R10", "busy after abort", busy_o, 0);
    wait_cyc(4);

    // R10 abort during conversion
    adc_en = 1'b1;
    lf_mode = 1'b0;
    wait_cyc(1);
    fire(0, 1, 1, "R10");
    wait_cyc(2);
    adc_en = 1'b0;
    wait_cyc(1);
    chk(busy_o == 0, "R10", "busy after conversion abort", busy_o, 0);

    wait_cyc(5);
    foreach (sb[i]) chk(1'b0, sb[i].req, "missing pulse kind", 0, sb[i].kind);
    report();
  end

endmodule